// File: doc/BRIEF.md
# UART Receive Queue with Character Timeout

This block buffers received characters for a 16550-style serial port. It takes bytes from the receiver and break events from the line monitor. It presents the oldest byte to the host's receive-register read, and it keeps the line-status flags that depend on the queue: data ready, overrun and break. It also compares the fill level against a software-chosen trigger threshold, and it raises a character-timeout flag when data has waited four character times without service.

The host controls the block by writing the FIFO control byte. Bit 0 selects queue mode, bit 1 flushes the queue, and bits 7:6 pick the trigger level. With bit 0 clear, the block acts as a single holding register in which a new byte overwrites the old one. The baud logic supplies one `char_tick_i` pulse per character time, and the timeout counts four of them. Interrupt encoding and the transmitter belong to neighbouring blocks.

Top module: `uart_rx_queue`

## Requirements
- R1: Control bits 7:6 select the trigger level: 00 gives 1, 01 gives 4, 10 gives 8 and 11 gives 14 bytes. In queue mode `trig_hit_o` is high when the count is at or above the level. In holding-register mode it equals data ready.
- R2: In queue mode (control bit 0 = 1), up to 16 bytes are held and read out in arrival order. `count_o` gives the fill level and `rd_data_o` shows the oldest byte before the read strobe.
- R3: A byte that arrives while the queue holds 16 bytes is discarded. The stored bytes stay unchanged and `overrun_o` is set.
- R4: In holding-register mode a new byte replaces the held one, and `overrun_o` is set if data ready was already high. A read clears data ready and break.
- R5: In queue mode, every received byte restarts a count of four character ticks. When the fourth tick arrives with the queue non-empty, `timeout_o` is set. With fewer ticks it stays clear.
- R6: A receive read clears `timeout_o` and restarts the four-tick count. A read that empties the queue clears data ready and break.
- R7: With the queue empty in queue mode, `rd_data_o` is 0x00 and a read leaves the count at zero.
- R8: A break event stores a 0x00 byte and sets both `break_o` and data ready.
- R9: Writing the control byte with bit 1 set, or with bit 0 different from the current mode, empties the queue. It also clears data ready, break and `timeout_o` and stops the timeout count.
- R10: A line-status read clears `break_o` and `overrun_o`. A read of the receive data does not clear them.
- R11: After reset the block is in holding-register mode with trigger level 1, count 0 and all flags low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | Received-byte strobe |
| rx_data_i | input | 8 | Received byte |
| brk_i | input | 1 | Break-detected strobe |
| rd_i | input | 1 | Receive-register read strobe |
| lsr_rd_i | input | 1 | Line-status read strobe |
| fcr_we_i | input | 1 | Control byte write strobe |
| fcr_data_i | input | 8 | Control byte |
| char_tick_i | input | 1 | One pulse per character time |
| rd_data_o | output | 8 | Oldest byte, or the held byte |
| count_o | output | 5 | Number of stored bytes |
| data_ready_o | output | 1 | Data ready flag |
| overrun_o | output | 1 | Overrun flag |
| break_o | output | 1 | Break flag |
| trig_hit_o | output | 1 | Fill level at or above the trigger |
| timeout_o | output | 1 | Character timeout pending |

## Verification
The queue is filled one byte below and exactly at each of the four trigger thresholds. This separates the level decode from an off-by-one comparison. It is then filled to 16 and sent one more byte, and the drained order shows whether the extra byte was dropped or overwrote a stored one. Tick sequences of three, then a restart, then four separate the restart on receive from a free-running count. A final four ticks with the queue emptied shows that an expiry on an empty queue stays silent. Holding-register mode is driven with back-to-back bytes, which tells overwrite-with-overrun apart from queue behaviour.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;
  function automatic int unsigned trig_level(input logic [1:0] code);
    case (code)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction
endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              push_i,
  input  logic              pop_i,
  input  logic [DATA_W-1:0] din_i,
  output logic [DATA_W-1:0] head_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              full_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign do_push = push_i && !full_o && !clr_i;
  assign do_pop  = pop_i && (cnt_q != '0) && !clr_i;
  assign head_o  = (cnt_q != '0) ? mem_q[rd_ptr_q] : '0;
  assign count_o = cnt_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_ptr_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (clr_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (do_push) wr_ptr_q <= nxt(wr_ptr_q);
      if (do_pop)  rd_ptr_q <= nxt(rd_ptr_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/rxq_timer.sv
module rxq_timer #(
  parameter int unsigned TICKS = 4,
  localparam int unsigned TW = $clog2(TICKS + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_i,
  input  logic restart_i,
  input  logic clr_pend_i,
  input  logic tick_i,
  input  logic nonempty_i,
  output logic pend_o
);
  logic          run_q, pend_q;
  logic [TW-1:0] cnt_q;

  assign pend_o = pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else if (stop_i) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      if (clr_pend_i) pend_q <= 1'b0;
      if (restart_i) begin
        run_q <= 1'b1;
        cnt_q <= '0;
      end else if (run_q && tick_i) begin
        if (cnt_q == TW'(TICKS - 1)) begin
          run_q <= 1'b0;
          cnt_q <= '0;
          if (nonempty_i) pend_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/uart_rx_queue.sv
module uart_rx_queue
  import uart_rxq_pkg::*;
#(
  parameter int unsigned DEPTH     = 16,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TMO_CHARS = 4,
  localparam int unsigned CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              brk_i,
  input  logic              rd_i,
  input  logic              lsr_rd_i,
  input  logic              fcr_we_i,
  input  logic [7:0]        fcr_data_i,
  input  logic              char_tick_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [CNT_W-1:0]  count_o,
  output logic              data_ready_o,
  output logic              overrun_o,
  output logic              break_o,
  output logic              trig_hit_o,
  output logic              timeout_o
);
  logic              fifo_en_q;
  logic [1:0]        trig_code_q;
  logic              ovr_q, brk_q, hold_v_q;
  logic [DATA_W-1:0] hold_q;
  logic              flush, byte_in, rd_empties, ovr_set;
  logic [DATA_W-1:0] byte_val, head;
  logic [CNT_W-1:0]  cnt;
  logic              full;

  // mode change forces a flush
  assign flush    = fcr_we_i && (fcr_data_i[1] || (fcr_data_i[0] != fifo_en_q));
  assign byte_in  = (rx_valid_i || brk_i) && !flush;
  assign byte_val = brk_i ? '0 : rx_data_i;
  assign rd_empties = rd_i && (!fifo_en_q || cnt <= CNT_W'(1));
  assign ovr_set  = byte_in && (fifo_en_q ? full : hold_v_q);

  rxq_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (flush),
    .push_i  (byte_in && fifo_en_q),
    .pop_i   (rd_i && fifo_en_q),
    .din_i   (byte_val),
    .head_o  (head),
    .count_o (cnt),
    .full_o  (full)
  );

  rxq_timer #(.TICKS(TMO_CHARS)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_i     (flush || !fifo_en_q),
    .restart_i  (fifo_en_q && (byte_in || rd_i)),
    .clr_pend_i (rd_i),
    .tick_i     (char_tick_i),
    .nonempty_i (cnt != '0),
    .pend_o     (timeout_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_en_q   <= 1'b0;
      trig_code_q <= 2'b00;
      ovr_q       <= 1'b0;
      brk_q       <= 1'b0;
      hold_q      <= '0;
      hold_v_q    <= 1'b0;
    end else begin
      if (fcr_we_i) begin
        fifo_en_q   <= fcr_data_i[0];
        trig_code_q <= fcr_data_i[7:6];
      end
      if (lsr_rd_i)     ovr_q <= 1'b0;
      if (ovr_set)      ovr_q <= 1'b1;
      if (flush || lsr_rd_i || rd_empties) brk_q <= 1'b0;
      if (brk_i && !flush) brk_q <= 1'b1;
      if (flush) begin
        hold_v_q <= 1'b0;
      end else if (byte_in && !fifo_en_q) begin
        hold_q   <= byte_val;
        hold_v_q <= 1'b1;
      end else if (rd_i && !fifo_en_q) begin
        hold_v_q <= 1'b0;
      end
    end
  end

  assign data_ready_o = fifo_en_q ? (cnt != '0) : hold_v_q;
  assign rd_data_o    = fifo_en_q ? head : hold_q;
  assign count_o      = fifo_en_q ? cnt : CNT_W'(hold_v_q);
  assign overrun_o    = ovr_q;
  assign break_o      = brk_q;
  assign trig_hit_o   = data_ready_o &&
                        (!fifo_en_q || cnt >= CNT_W'(trig_level(trig_code_q)));
endmodule

// File: rtl/uart_rx_queue_chk.sv
module uart_rx_queue_chk #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              fifo_en_q,
  input logic              rx_valid_i,
  input logic              brk_i,
  input logic              rd_i,
  input logic              lsr_rd_i,
  input logic              fcr_we_i,
  input logic [7:0]        fcr_data_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic [CNT_W-1:0]  count_o,
  input logic              data_ready_o,
  input logic              overrun_o,
  input logic              break_o,
  input logic              timeout_o
);
  p_count_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_o <= CNT_W'(DEPTH));

  p_full_drop_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_q && count_o == CNT_W'(DEPTH) && rx_valid_i && !rd_i && !fcr_we_i
    |=> overrun_o && count_o == CNT_W'(DEPTH));

  p_hold_ovr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fifo_en_q && data_ready_o && rx_valid_i && !fcr_we_i && !lsr_rd_i |=> overrun_o);

  p_tmo_needs_data_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    timeout_o |-> data_ready_o);

  p_rd_clears_tmo_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !timeout_o);

  p_empty_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_en_q && count_o == '0 |-> rd_data_o == '0);

  p_break_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i && !fcr_we_i |=> break_o && data_ready_o);

  p_flush_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fcr_we_i && fcr_data_i[1] |=> count_o == '0 && !data_ready_o && !timeout_o && !break_o);

  p_lsr_clr_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lsr_rd_i && !rx_valid_i && !brk_i |=> !break_o && !overrun_o);
endmodule

bind uart_rx_queue uart_rx_queue_chk #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fifo_en_q    (fifo_en_q),
  .rx_valid_i   (rx_valid_i),
  .brk_i        (brk_i),
  .rd_i         (rd_i),
  .lsr_rd_i     (lsr_rd_i),
  .fcr_we_i     (fcr_we_i),
  .fcr_data_i   (fcr_data_i),
  .rd_data_o    (rd_data_o),
  .count_o      (count_o),
  .data_ready_o (data_ready_o),
  .overrun_o    (overrun_o),
  .break_o      (break_o),
  .timeout_o    (timeout_o)
);

// File: tb/test_uart_rx_queue.sv
module test_uart_rx_queue;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       rx_valid_i = 1'b0;
  logic [7:0] rx_data_i = '0;
  logic       brk_i = 1'b0;
  logic       rd_i = 1'b0;
  logic       lsr_rd_i = 1'b0;
  logic       fcr_we_i = 1'b0;
  logic [7:0] fcr_data_i = '0;
  logic       char_tick_i = 1'b0;
  logic [7:0] rd_data_o;
  logic [4:0] count_o;
  logic       data_ready_o, overrun_o, break_o, trig_hit_o, timeout_o;

  int checks = 0;
  int failures = 0;

  always #10 clk_i = ~clk_i;

  uart_rx_queue i_uart_rx_queue (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic fcr_wr(input logic [7:0] v);
    @(negedge clk_i); fcr_we_i = 1'b1; fcr_data_i = v;
    @(negedge clk_i); fcr_we_i = 1'b0;
  endtask
  task automatic rx(input logic [7:0] v);
    @(negedge clk_i); rx_valid_i = 1'b1; rx_data_i = v;
    @(negedge clk_i); rx_valid_i = 1'b0;
  endtask
  task automatic brk();
    @(negedge clk_i); brk_i = 1'b1;
    @(negedge clk_i); brk_i = 1'b0;
  endtask
  task automatic rd();
    @(negedge clk_i); rd_i = 1'b1;
    @(negedge clk_i); rd_i = 1'b0;
  endtask
  task automatic lsr_rd();
    @(negedge clk_i); lsr_rd_i = 1'b1;
    @(negedge clk_i); lsr_rd_i = 1'b0;
  endtask
  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); char_tick_i = 1'b1;
      @(negedge clk_i); char_tick_i = 1'b0;
    end
  endtask

  task automatic t_reset();
    chk("R11 count", count_o, 0);
    chk("R11 flags", {data_ready_o, overrun_o, break_o, trig_hit_o, timeout_o}, 0);
  endtask

  task automatic t_order();
    fcr_wr(8'h01);
    rx(8'hA1); rx(8'hB2); rx(8'hC3);
    chk("R2 count", count_o, 3);
    chk("R1 trig lvl1", trig_hit_o, 1);
    chk("R2 head0", rd_data_o, 8'hA1); rd();
    chk("R2 head1", rd_data_o, 8'hB2); rd();
    chk("R2 head2", rd_data_o, 8'hC3); rd();
    chk("R6 empty dr", data_ready_o, 0);
  endtask

  task automatic t_trigger();
    fcr_wr(8'h43);
    for (int i = 0; i < 3; i++) rx(8'(i));
    chk("R1 lvl4 below", trig_hit_o, 0);
    rx(8'h03);
    chk("R1 lvl4 at", trig_hit_o, 1);
    fcr_wr(8'h83);
    for (int i = 0; i < 7; i++) rx(8'(i));
    chk("R1 lvl8 below", trig_hit_o, 0);
    rx(8'h07);
    chk("R1 lvl8 at", trig_hit_o, 1);
    fcr_wr(8'hC3);
    for (int i = 0; i < 13; i++) rx(8'(i));
    chk("R1 lvl14 below", trig_hit_o, 0);
    rx(8'h0D);
    chk("R1 lvl14 at", trig_hit_o, 1);
  endtask

  task automatic t_overrun();
    fcr_wr(8'h03);
    for (int i = 0; i < 16; i++) rx(8'(8'h10 + i));
    chk("R3 full count", count_o, 16);
    chk("R3 no ovr yet", overrun_o, 0);
    rx(8'hEE);
    chk("R3 count kept", count_o, 16);
    chk("R3 ovr set", overrun_o, 1);
    for (int i = 0; i < 16; i++) begin
      chk("R3 contents", rd_data_o, 8'h10 + i);
      rd();
    end
    chk("R10 ovr kept on rx read", overrun_o, 1);
    lsr_rd();
    chk("R10 ovr cleared", overrun_o, 0);
  endtask

  task automatic t_empty();
    chk("R7 empty data", rd_data_o, 0);
    rd();
    chk("R7 count stays", count_o, 0);
    chk("R7 empty data after", rd_data_o, 0);
  endtask

  task automatic t_timeout();
    fcr_wr(8'h03);
    rx(8'h31); tick(3);
    chk("R5 three ticks", timeout_o, 0);
    rx(8'h32); tick(3);
    chk("R5 restarted", timeout_o, 0);
    tick(1);
    chk("R5 fourth tick", timeout_o, 1);
    rd();
    chk("R6 rd clears tmo", timeout_o, 0);
    chk("R6 one left", count_o, 1);
    tick(4);
    chk("R6 restart after rd", timeout_o, 1);
    rd();
    chk("R6 empty", {data_ready_o, timeout_o}, 0);
    tick(4);
    chk("R5 empty no tmo", timeout_o, 0);
  endtask

  task automatic t_break();
    fcr_wr(8'h03);
    brk();
    chk("R8 count", count_o, 1);
    chk("R8 flags", {break_o, data_ready_o}, 2'b11);
    chk("R8 zero byte", rd_data_o, 0);
    lsr_rd();
    chk("R10 brk cleared", {break_o, data_ready_o}, 2'b01);
    brk();
    rd();
    chk("R6 brk kept, not empty", {break_o, count_o}, {1'b1, 5'd1});
    rd();
    chk("R6 brk cleared on empty", {break_o, data_ready_o}, 0);
  endtask

  task automatic t_flush();
    fcr_wr(8'h01);
    rx(8'h44); rx(8'h55); brk();
    fcr_wr(8'h03);
    chk("R9 bit1 flush", {count_o, data_ready_o, break_o}, 0);
    rx(8'h66); rx(8'h77);
    fcr_wr(8'h00);
    chk("R9 disable flush", {count_o, data_ready_o}, 0);
  endtask

  task automatic t_hold();
    rx(8'h5A);
    chk("R4 dr", {data_ready_o, count_o}, {1'b1, 5'd1});
    chk("R4 data", rd_data_o, 8'h5A);
    chk("R1 hold trig", trig_hit_o, 1);
    rx(8'h6B);
    chk("R4 overwrite", rd_data_o, 8'h6B);
    chk("R4 ovr", overrun_o, 1);
    tick(4);
    chk("R5 no tmo in hold mode", timeout_o, 0);
    brk();
    chk("R8 hold break", {break_o, data_ready_o, rd_data_o}, {2'b11, 8'h00});
    rd();
    chk("R4 rd clears", {data_ready_o, break_o}, 0);
    lsr_rd();
    chk("R10 ovr clr", overrun_o, 0);
    rx(8'h12);
    fcr_wr(8'h01);
    chk("R9 enable flush", {count_o, data_ready_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset();
    t_order();
    t_trigger();
    t_overrun();
    t_empty();
    t_timeout();
    t_break();
    t_flush();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule